// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a virtual page number into a physical page number when the translation buffer in front of it has no entry for that page. It takes one request at a time, carrying the page number, the page offset and the kind of access (read or write, user or kernel). From these it computes where the matching table entry lives in memory: a base register plus four bytes per virtual page. It then issues one word read on a valid/ready memory request port and waits for the read data.

The fetched entry is decoded and checked. If the entry is not present, the walk ends in a page fault. If the access breaks the entry's permissions, the walk ends in a protection violation. Otherwise the walk returns the physical page number, the page's flag bits and the full physical address, which is the physical page number placed above the untouched 12-bit offset. Each walk ends with a single-cycle response. The base register is loaded through its own write port, and that port only takes effect while no walk is in progress.

Top module: `pgwalk_top`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `mem_req_valid` and `resp_valid` are 0, and the table base is 0.
- R2: The entry address on `mem_req_addr` is base + 4 × VPN, taken modulo 2^32. `mem_req_valid` and this address stay unchanged until the cycle in which `mem_req_ready` is high.
- R3: Only one walk is in flight at a time. `req_ready` is high only while idle, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R4: An entry word is decoded as follows: bit 31 present, bit 30 user-accessible, bit 29 writable, bit 28 referenced, bit 27 dirty, and bits 17..0 the physical page number.
- R5: An entry with bit 31 clear gives status 01 (page fault), with `resp_ppn` and `resp_flags` zero. A page fault takes priority over any protection check.
- R6: A write (`req_write`=1) to a present entry whose writable bit is clear gives status 10 (protection violation), with zero page number and flags.
- R7: A user access (`req_user`=1) to a present entry whose user bit is clear gives status 10. A kernel access (`req_user`=0) ignores the user bit.
- R8: A permitted access gives status 00. `resp_ppn` equals entry bits 17..0, and `resp_flags` is {user, writable, referenced, dirty}, which is entry bits 30..27.
- R9: `resp_valid` is high for exactly one cycle per accepted request, in the cycle after the read data is taken (`mem_rsp_valid` high while waiting). `req_ready` is high again in the next cycle.
- R10: A base write while idle applies to requests accepted in later cycles. A base write while a walk is in progress is ignored.
- R11: `resp_paddr` is {`resp_ppn`, request offset}, using the offset latched when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | 32 | New table base byte address |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vpn | input | 20 | Virtual page number |
| req_offset | input | 12 | Page offset carried to the physical address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user-mode access, 0 = kernel |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry word |
| resp_valid | output | 1 | Walk result, one cycle |
| resp_status | output | 2 | 00 ok, 01 page fault, 10 protection violation |
| resp_ppn | output | 18 | Physical page number (zero unless ok) |
| resp_flags | output | 4 | {user, writable, referenced, dirty} (zero unless ok) |
| resp_paddr | output | 30 | Physical address {ppn, offset} |

## Verification
The embedded properties assume that memory never returns read data unless a read has been accepted, and that reset is applied before the first request. The bench memory model raises `mem_rsp_valid` only in the wait phase that follows an accepted read, and only ever for one cycle. It also holds each request for a single cycle, so it never presents a second request while busy. Random walks vary the handshake delays, the access type and the entry bits, with present entries made more likely. Directed walks cover address wraparound, fault-over-protection priority and base writes made during a walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int VA_W     = 32;
    localparam int PG_OFF_W = 12;
    localparam int VPN_W    = VA_W - PG_OFF_W;
    localparam int PPN_W    = 18;
    localparam int MEM_AW   = 32;
    localparam int PTE_W    = 32;

    // entry word layout
    localparam int PTE_PRESENT_BIT = 31;
    localparam int PTE_USER_BIT    = 30;
    localparam int PTE_WRITE_BIT   = 29;
    localparam int PTE_REF_BIT     = 28;
    localparam int PTE_DIRTY_BIT   = 27;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        STAT_OK      = 2'b00,
        STAT_PGFAULT = 2'b01,
        STAT_PROT    = 2'b10
    } walk_status_e;

    typedef struct packed {
        logic user;
        logic writable;
        logic referenced;
        logic dirty;
    } pte_flags_t;

    function automatic logic [MEM_AW-1:0] entry_address(
        input logic [MEM_AW-1:0] base,
        input logic [VPN_W-1:0]  vpn
    );
        return base + (MEM_AW'(vpn) << 2);
    endfunction

endpackage

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
    import pgwalk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic req_ready,
    output logic accept,
    output logic mem_req_valid,
    output logic capture,
    output logic resp_valid
);

    walk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_RESP;
            ST_RESP:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_ready && req_valid;
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign capture       = (state_q == ST_WAIT) && mem_rsp_valid;
    assign resp_valid    = (state_q == ST_RESP);

    // R2: request held until memory takes it
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

    // R9: response is a single-cycle pulse followed by idle
    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));

endmodule

// File: rtl/pgwalk_base_addr.sv
module pgwalk_base_addr #(
    parameter int MEM_AW = pgwalk_pkg::MEM_AW,
    parameter int VPN_W  = pgwalk_pkg::VPN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [MEM_AW-1:0] base_wdata,
    input  logic              idle,
    input  logic              accept,
    input  logic [VPN_W-1:0]  vpn,
    output logic [MEM_AW-1:0] entry_addr
);

    logic [MEM_AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            entry_addr <= '0;
        end else begin
            if (base_we && idle) base_q <= base_wdata;
            if (accept) entry_addr <= base_q + (MEM_AW'(vpn) << 2);
        end
    end

    // R10: base is frozen while a walk is in progress
    assert_base_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (!idle) |=> $stable(base_q));

endmodule

// File: rtl/pgwalk_pte_check.sv
module pgwalk_pte_check
    import pgwalk_pkg::*;
#(
    parameter int PTE_W_P = pgwalk_pkg::PTE_W,
    parameter int PPN_W_P = pgwalk_pkg::PPN_W
) (
    input  logic [PTE_W_P-1:0] pte,
    input  logic               is_write,
    input  logic               is_user,
    output logic [1:0]         status,
    output logic [PPN_W_P-1:0] ppn,
    output pte_flags_t         flags
);

    pte_flags_t raw_flags;
    logic       present;
    logic       prot_bad;
    logic       unused_bits;

    assign present   = pte[PTE_PRESENT_BIT];
    assign raw_flags = '{user:       pte[PTE_USER_BIT],
                         writable:   pte[PTE_WRITE_BIT],
                         referenced: pte[PTE_REF_BIT],
                         dirty:      pte[PTE_DIRTY_BIT]};
    assign prot_bad  = (is_write && !raw_flags.writable) ||
                       (is_user  && !raw_flags.user);
    assign unused_bits = ^pte[PTE_DIRTY_BIT-1:PPN_W_P];

    always_comb begin
        if (!present) begin
            status = STAT_PGFAULT;
            ppn    = '0;
            flags  = '0;
        end else if (prot_bad) begin
            status = STAT_PROT;
            ppn    = '0;
            flags  = '0;
        end else begin
            status = STAT_OK;
            ppn    = pte[PPN_W_P-1:0];
            flags  = raw_flags;
        end
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int MEM_AW_P   = pgwalk_pkg::MEM_AW,
    parameter int VPN_W_P    = pgwalk_pkg::VPN_W,
    parameter int PG_OFF_W_P = pgwalk_pkg::PG_OFF_W,
    parameter int PPN_W_P    = pgwalk_pkg::PPN_W,
    parameter int PTE_W_P    = pgwalk_pkg::PTE_W,
    localparam int PA_W      = PPN_W_P + PG_OFF_W_P
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  base_we,
    input  logic [MEM_AW_P-1:0]   base_wdata,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VPN_W_P-1:0]    req_vpn,
    input  logic [PG_OFF_W_P-1:0] req_offset,
    input  logic                  req_write,
    input  logic                  req_user,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [MEM_AW_P-1:0]   mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [PTE_W_P-1:0]    mem_rsp_data,
    output logic                  resp_valid,
    output logic [1:0]            resp_status,
    output logic [PPN_W_P-1:0]    resp_ppn,
    output logic [3:0]            resp_flags,
    output logic [PA_W-1:0]       resp_paddr
);

    logic                  accept;
    logic                  capture;
    logic [PG_OFF_W_P-1:0] offset_q;
    logic                  write_q;
    logic                  user_q;
    logic [PTE_W_P-1:0]    pte_q;
    pte_flags_t            flags_w;

    pgwalk_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .req_ready     (req_ready),
        .accept        (accept),
        .mem_req_valid (mem_req_valid),
        .capture       (capture),
        .resp_valid    (resp_valid)
    );

    pgwalk_base_addr #(.MEM_AW(MEM_AW_P), .VPN_W(VPN_W_P)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .idle       (req_ready),
        .accept     (accept),
        .vpn        (req_vpn),
        .entry_addr (mem_req_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
            write_q  <= 1'b0;
            user_q   <= 1'b0;
            pte_q    <= '0;
        end else begin
            if (accept) begin
                offset_q <= req_offset;
                write_q  <= req_write;
                user_q   <= req_user;
            end
            if (capture) pte_q <= mem_rsp_data;
        end
    end

    pgwalk_pte_check #(.PTE_W_P(PTE_W_P), .PPN_W_P(PPN_W_P)) u_check (
        .pte      (pte_q),
        .is_write (write_q),
        .is_user  (user_q),
        .status   (resp_status),
        .ppn      (resp_ppn),
        .flags    (flags_w)
    );

    assign resp_flags = flags_w;
    assign resp_paddr = {resp_ppn, offset_q};

    // R2: address steady while the read waits for acceptance
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

    // R5: a failed walk exposes no translation
    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_status != 2'b00) |-> (resp_ppn == '0 && resp_flags == '0));

    // R6: only the three defined status codes appear
    assert_status_legal_R6: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_status != 2'b11));

    // R3: no new request is taken while the read request is outstanding
    assert_single_walk_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

endmodule

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic [11:0] req_offset = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        resp_valid;
    logic [1:0]  resp_status;
    logic [17:0] resp_ppn;
    logic [3:0]  resp_flags;
    logic [29:0] resp_paddr;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_base = '0;

    always #4 clk = ~clk;

    pgwalk_top dut_i (
        .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .req_offset(req_offset), .req_write(req_write), .req_user(req_user),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid),
        .resp_status(resp_status), .resp_ppn(resp_ppn),
        .resp_flags(resp_flags), .resp_paddr(resp_paddr)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_status(input logic [31:0] pte, input bit wr, input bit usr);
        if (!pte[31]) return 2'b01;
        if ((wr && !pte[29]) || (usr && !pte[30])) return 2'b10;
        return 2'b00;
    endfunction

    task automatic base_load(input logic [31:0] val);
        @(negedge clk);
        base_we = 1'b1; base_wdata = val;
        @(negedge clk);
        base_we = 1'b0; base_wdata = $urandom;
        exp_base = val;
    endtask

    task automatic walk(input logic [19:0] vpn, input logic [11:0] off, input bit wr, input bit usr,
                        input logic [31:0] pte, input int rdly, input int ddly, input bit busy_bw,
                        input string tag);
        logic [31:0] ea;
        logic [1:0]  st;
        logic [17:0] eppn;
        logic [3:0]  efl;
        ea   = exp_base + {10'd0, vpn, 2'b00};
        st   = exp_status(pte, wr, usr);
        eppn = (st == 2'b00) ? pte[17:0] : 18'd0;
        efl  = (st == 2'b00) ? pte[30:27] : 4'd0;
        @(negedge clk);
        req_valid = 1'b1; req_vpn = vpn; req_offset = off; req_write = wr; req_user = usr;
        #1;
        chk(req_ready == 1'b1, "R3 ready when idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0; req_vpn = 20'($urandom); req_offset = 12'($urandom);
        req_write = ~wr; req_user = ~usr;
        for (int i = 0; i < rdly; i++) begin
            #1;
            chk(mem_req_valid == 1'b1, "R2 request held", 64'(mem_req_valid), 64'd1);
            chk(mem_req_addr == ea, {"R2 address held ", tag}, 64'(mem_req_addr), 64'(ea));
            chk(req_ready == 1'b0, "R3 busy", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        mem_req_ready = 1'b1;
        #1;
        chk(mem_req_valid == 1'b1, "R2 request valid", 64'(mem_req_valid), 64'd1);
        chk(mem_req_addr == ea, {"R2 entry address ", tag}, 64'(mem_req_addr), 64'(ea));
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < ddly; i++) begin
            #1;
            chk(!mem_req_valid && !resp_valid, "R9 quiet while waiting",
                64'({mem_req_valid, resp_valid}), 64'd0);
            if (busy_bw && i == 0) begin
                base_we = 1'b1; base_wdata = $urandom;
            end
            @(negedge clk);
            base_we = 1'b0;
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
        #1;
        chk(resp_valid == 1'b1, {"R9 response pulse ", tag}, 64'(resp_valid), 64'd1);
        chk(resp_status == st, {"R5 R6 R7 R8 status ", tag}, 64'(resp_status), 64'(st));
        chk(resp_ppn == eppn, {"R4 R8 ppn ", tag}, 64'(resp_ppn), 64'(eppn));
        chk(resp_flags == efl, {"R4 R8 flags ", tag}, 64'(resp_flags), 64'(efl));
        chk(resp_paddr == {eppn, off}, {"R11 paddr ", tag}, 64'(resp_paddr), 64'({eppn, off}));
        @(negedge clk);
        #1;
        chk(resp_valid == 1'b0, "R9 single cycle", 64'(resp_valid), 64'd0);
        chk(req_ready == 1'b1, "R9 ready again", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        n_fail++;
        n_chk++;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk(resp_valid == 1'b0, "R1 resp_valid", 64'(resp_valid), 64'd0);

        // R1 base is zero, R8 full permissions kernel read
        walk(20'h00005, 12'h123, 1'b0, 1'b0, 32'hF803_1234, 0, 0, 1'b0, "R1 base zero");
        // R10 base load while idle
        base_load(32'h0010_0000);
        // R5 not present
        walk(20'h00042, 12'h040, 1'b0, 1'b0, 32'h0000_0ABC, 1, 2, 1'b0, "R5 fault");
        // R5 priority over protection
        walk(20'h00043, 12'h7FF, 1'b1, 1'b1, 32'h0000_0000, 0, 1, 1'b0, "R5 priority");
        // R6 write to read-only page
        walk(20'h01000, 12'h001, 1'b1, 1'b0, 32'hC000_00AA, 2, 0, 1'b0, "R6 readonly write");
        // R6 read of read-only page is fine
        walk(20'h01000, 12'h001, 1'b0, 1'b1, 32'hD000_00AA, 0, 0, 1'b0, "R6 readonly read");
        // R7 user access to kernel page
        walk(20'h00777, 12'hABC, 1'b0, 1'b1, 32'hA800_3FFF, 1, 1, 1'b0, "R7 user kernel");
        // R7 kernel write to kernel page allowed
        walk(20'h00777, 12'hABC, 1'b1, 1'b0, 32'hA800_3FFF, 0, 3, 1'b0, "R7 kernel access");
        // R10 base write during walk ignored, seen in this and next walk
        walk(20'h00010, 12'h010, 1'b0, 1'b0, 32'hE000_0001, 1, 2, 1'b1, "R10 busy write");
        walk(20'h00011, 12'h010, 1'b0, 1'b0, 32'hE000_0002, 0, 0, 1'b0, "R10 after busy");
        // R2 wraparound of the entry address
        base_load(32'hFFFF_F000);
        walk(20'hFFFFF, 12'hFFF, 1'b0, 1'b0, 32'hFFFF_FFFF, 0, 0, 1'b0, "R2 wrap");

        for (int n = 0; n < 150; n++) begin
            logic [31:0] pte;
            if (n % 25 == 0) base_load($urandom);
            pte = $urandom;
            if (($urandom % 4) != 0) pte[31] = 1'b1;
            walk(20'($urandom), 12'($urandom), 1'($urandom), 1'($urandom), pte,
                 int'($urandom % 4), int'($urandom % 4), (($urandom % 5) == 0), "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule